// File: doc/BRIEF.md
# Fixed-point RGB to YCbCr converter

The block turns one 8-bit red, green and blue pixel per clock into studio-range luma (Y) and two colour-difference components (Cb, Cr). Every output channel is a three-term dot product of the input components with fixed coefficients carrying 13 fraction bits. The sum is arithmetically shifted right by 13 and then a constant offset is added: 16 for luma and 128 for both chroma channels.

A qualifier travels alongside the data. A pixel presented with `valid_i` high comes out exactly two clocks later with `valid_o` high. The first register stage holds the nine products and the second holds the shifted, offset results. Pixels presented with `valid_i` low are dropped. In cycles with `valid_o` low, the outputs keep the last result they produced. The stream accepts a new pixel on every cycle, with no stall or backpressure.

Top module: `rgb_ycc_conv`

## Requirements
- R1: `y_o` = 16 + floor((2104·R + 4130·G + 802·B) / 8192) for the pixel accepted two clocks earlier.
- R2: `cb_o` = 128 + floor((3598·B − 1217·R − 2382·G) / 8192). The division rounds toward minus infinity for negative sums, so R=G=255, B=0 gives 15.
- R3: `cr_o` = 128 + floor((3598·R − 3015·G − 583·B) / 8192), with the same floor rounding for negative sums.
- R4: `valid_o` in any cycle equals `valid_i` as sampled two rising clock edges earlier.
- R5: While `valid_o` is low, `y_o`, `cb_o` and `cr_o` hold the value they had in the previous cycle.
- R6: While `rst_ni` is low, `valid_o` is 0 and `y_o`, `cb_o` and `cr_o` are 0.
- R7: For every 8-bit input, luma lies within 16..235 and both chroma outputs lie within 15..239, with no wrap of the 8-bit result.
- R8: Pixels presented on consecutive cycles each produce a result, in the order they were presented.
- R9: A pixel presented with `valid_i` low produces no output. It neither appears as a result nor changes the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel qualifier |
| r_i | input | COMP_W | Red component |
| g_i | input | COMP_W | Green component |
| b_i | input | COMP_W | Blue component |
| valid_o | output | 1 | Result qualifier, `valid_i` delayed by two clocks |
| y_o | output | COMP_W | Luma |
| cb_o | output | COMP_W | Blue colour difference |
| cr_o | output | COMP_W | Red colour difference |

## Verification
The products for a new pixel are captured in the same cycle as the previous pixel's sum, shift and offset, so a stage that loads or holds on the wrong qualifier corrupts a neighbour. The bench provokes this overlap in three ways:
- a back-to-back sweep over a regular grid of the RGB cube,
- a sweep in which every third slot carries garbage data with `valid_i` low,
- a random stream with random bubbles.

Every result is compared against an integer model computed from the formulas, in order. In idle cycles the outputs must be unchanged, and the `valid_o` pattern must match the `valid_i` pattern two edges later.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  localparam int NUM_CH     = 3;
  localparam int COEF_W     = 14;
  localparam int FRAC_W     = 13;
  localparam int PIPE_DEPTH = 2;

  // expected output ranges for 8-bit components
  localparam int LUMA_MIN   = 16;
  localparam int LUMA_MAX   = 235;
  localparam int CHROMA_MIN = 15;
  localparam int CHROMA_MAX = 239;

  // row: 0 luma, 1 blue diff, 2 red diff; col: 0 R, 1 G, 2 B
  function automatic int coef_of(int row, int col);
    case (row * NUM_CH + col)
      0:       return 2104;
      1:       return 4130;
      2:       return 802;
      3:       return -1217;
      4:       return -2382;
      5:       return 3598;
      6:       return 3598;
      7:       return -3015;
      default: return -583;
    endcase
  endfunction

  function automatic int offset_of(int row);
    return (row == 0) ? 16 : 128;
  endfunction
endpackage

// File: rtl/ycc_valid_pipe.sv
module ycc_valid_pipe #(
  parameter int DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic [DEPTH-1:0] stage_o
);
  logic [DEPTH-1:0] vld_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) vld_q <= '0;
        else         vld_q <= valid_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) vld_q <= '0;
        else         vld_q <= {vld_q[DEPTH-2:0], valid_i};
      end
    end
  endgenerate

  assign stage_o = vld_q;
endmodule

// File: rtl/ycc_mult_stage.sv
module ycc_mult_stage import ycc_pkg::*; #(
  parameter int COMP_W = 8,
  parameter int PROD_W = COMP_W + 1 + COEF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [COMP_W-1:0]        pix_i  [NUM_CH],
  output logic signed [PROD_W-1:0] prod_o [NUM_CH][NUM_CH]
);
  generate
    for (genvar row = 0; row < NUM_CH; row++) begin : g_row
      for (genvar col = 0; col < NUM_CH; col++) begin : g_col
        localparam logic signed [COEF_W-1:0] K = COEF_W'(coef_of(row, col));
        logic signed [COMP_W:0]   comp_s;
        logic signed [PROD_W-1:0] prod_q;

        assign comp_s = {1'b0, pix_i[col]};

        // enable-gated: idle cycles leave products untouched
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)      prod_q <= '0;
          else if (valid_i) prod_q <= PROD_W'(comp_s) * PROD_W'(K);
        end

        assign prod_o[row][col] = prod_q;
      end
    end
  endgenerate
endmodule

// File: rtl/ycc_sum_stage.sv
module ycc_sum_stage import ycc_pkg::*; #(
  parameter int COMP_W = 8,
  parameter int PROD_W = COMP_W + 1 + COEF_W,
  parameter int SUM_W  = PROD_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [PROD_W-1:0] prod_i [NUM_CH][NUM_CH],
  output logic [COMP_W-1:0]        res_o  [NUM_CH]
);
  generate
    for (genvar row = 0; row < NUM_CH; row++) begin : g_row
      logic signed [SUM_W-1:0] acc;
      logic signed [SUM_W-1:0] scaled;
      logic signed [SUM_W-1:0] biased;
      logic [COMP_W-1:0]       res_q;

      always_comb begin
        acc = '0;
        for (int c = 0; c < NUM_CH; c++) acc = acc + SUM_W'(prod_i[row][c]);
      end

      // arithmetic shift: negative sums floor toward minus infinity
      assign scaled = acc >>> FRAC_W;
      assign biased = scaled + SUM_W'(offset_of(row));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      res_q <= '0;
        else if (valid_i) res_q <= biased[COMP_W-1:0];
      end

      assign res_o[row] = res_q;

      // R7
      no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |-> (biased[SUM_W-1:COMP_W] == '0));
    end
  endgenerate
endmodule

// File: rtl/rgb_ycc_conv.sv
module rgb_ycc_conv import ycc_pkg::*; #(
  parameter int COMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [COMP_W-1:0] r_i,
  input  logic [COMP_W-1:0] g_i,
  input  logic [COMP_W-1:0] b_i,
  output logic              valid_o,
  output logic [COMP_W-1:0] y_o,
  output logic [COMP_W-1:0] cb_o,
  output logic [COMP_W-1:0] cr_o
);
  localparam int PROD_W = COMP_W + 1 + COEF_W;
  localparam int SUM_W  = PROD_W + 2;

  logic [COMP_W-1:0]        pix  [NUM_CH];
  logic signed [PROD_W-1:0] prod [NUM_CH][NUM_CH];
  logic [COMP_W-1:0]        res  [NUM_CH];
  logic [PIPE_DEPTH-1:0]    vld;

  assign pix[0] = r_i;
  assign pix[1] = g_i;
  assign pix[2] = b_i;

  ycc_valid_pipe #(.DEPTH(PIPE_DEPTH)) u_vld (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .stage_o(vld)
  );

  ycc_mult_stage #(.COMP_W(COMP_W), .PROD_W(PROD_W)) u_mult (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .pix_i  (pix),
    .prod_o (prod)
  );

  ycc_sum_stage #(.COMP_W(COMP_W), .PROD_W(PROD_W), .SUM_W(SUM_W)) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(vld[0]),
    .prod_i (prod),
    .res_o  (res)
  );

  assign valid_o = vld[PIPE_DEPTH-1];
  assign y_o     = res[0];
  assign cb_o    = res[1];
  assign cr_o    = res[2];

  // edges since reset, saturating; keeps $past inside the post-reset window
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  // R4
  lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (valid_o == $past(valid_i, 2)));

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != 2'd0 && !valid_o) |-> ($stable(y_o) && $stable(cb_o) && $stable(cr_o)));

  // R7
  luma_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (y_o >= COMP_W'(LUMA_MIN) && y_o <= COMP_W'(LUMA_MAX)));

  // R7
  chroma_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cb_o >= COMP_W'(CHROMA_MIN) && cb_o <= COMP_W'(CHROMA_MAX) &&
                 cr_o >= COMP_W'(CHROMA_MIN) && cr_o <= COMP_W'(CHROMA_MAX)));
endmodule

// File: tb/rgb_ycc_conv_tb_top.sv
`timescale 1ns/1ps
module rgb_ycc_conv_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] r_i = '0, g_i = '0, b_i = '0;
  logic       valid_o;
  logic [7:0] y_o, cb_o, cr_o;

  int n_chk = 0, n_err = 0;
  int wr_ptr = 0, rd_ptr = 0;
  int exp_y [8], exp_cb [8], exp_cr [8];
  logic [1:0] vh;
  logic [7:0] py, pcb, pcr;
  bit running = 1'b0;

  always #2 clk = ~clk;

  rgb_ycc_conv #(.COMP_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .r_i(r_i), .g_i(g_i), .b_i(b_i),
    .valid_o(valid_o), .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o)
  );

  function automatic int floor13(int s);
    return s >>> 13;
  endfunction
  function automatic int ref_y(int r, int g, int b);
    return 16 + floor13(2104*r + 4130*g + 802*b);
  endfunction
  function automatic int ref_cb(int r, int g, int b);
    return 128 + floor13(3598*b - 1217*r - 2382*g);
  endfunction
  function automatic int ref_cr(int r, int g, int b);
    return 128 + floor13(3598*r - 3015*g - 583*b);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int r, input int g, input int b, input bit v);
    @(negedge clk);
    valid_i = v;
    r_i = 8'(r); g_i = 8'(g); b_i = 8'(b);
    if (v) begin
      exp_y [wr_ptr % 8] = ref_y(r, g, b);
      exp_cb[wr_ptr % 8] = ref_cb(r, g, b);
      exp_cr[wr_ptr % 8] = ref_cr(r, g, b);
      wr_ptr++;
    end
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) vh <= '0;
    else        vh <= {vh[0], valid_i};

  always @(negedge clk) begin
    if (running) begin
      chk(valid_o == vh[1], "R4 valid latency", int'(valid_o), int'(vh[1]));
      if (valid_o) begin
        if (rd_ptr >= wr_ptr) begin
          chk(1'b0, "R9 spurious result", rd_ptr, wr_ptr);
        end else begin
          chk(int'(y_o)  == exp_y [rd_ptr % 8], "R1 luma",     int'(y_o),  exp_y [rd_ptr % 8]);
          chk(int'(cb_o) == exp_cb[rd_ptr % 8], "R2 blue diff", int'(cb_o), exp_cb[rd_ptr % 8]);
          chk(int'(cr_o) == exp_cr[rd_ptr % 8], "R3 red diff",  int'(cr_o), exp_cr[rd_ptr % 8]);
          chk(y_o >= 16 && y_o <= 235, "R7 luma range", int'(y_o), 16);
          chk(cb_o >= 15 && cb_o <= 239 && cr_o >= 15 && cr_o <= 239,
              "R7 chroma range", int'(cb_o), int'(cr_o));
          rd_ptr++;
        end
      end else begin
        chk(y_o == py,   "R5 hold luma",  int'(y_o),  int'(py));
        chk(cb_o == pcb, "R5 hold cb",    int'(cb_o), int'(pcb));
        chk(cr_o == pcr, "R5 hold cr",    int'(cr_o), int'(pcr));
      end
    end
    py = y_o; pcb = cb_o; pcr = cr_o;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    chk(valid_o == 1'b0, "R6 reset valid", int'(valid_o), 0);
    chk(y_o == 0 && cb_o == 0 && cr_o == 0, "R6 reset data", int'(y_o), 0);
    rst_n = 1'b1;
    running = 1'b1;

    // corners and primaries, back to back (R2 floor case: yellow gives cb 15)
    push(0, 0, 0, 1);       push(255, 255, 255, 1);
    push(255, 0, 0, 1);     push(0, 255, 0, 1);
    push(0, 0, 255, 1);     push(255, 255, 0, 1);
    push(0, 255, 255, 1);   push(255, 0, 255, 1);
    push(0, 0, 0, 0);
    push(0, 0, 0, 0);
    push(0, 0, 0, 0);

    // R8 grid sweep, one pixel per cycle
    for (int r = 0; r <= 255; r += 15)
      for (int g = 0; g <= 255; g += 15)
        for (int b = 0; b <= 255; b += 15)
          push(r, g, b, 1);

    // R9 every third slot carries garbage with valid low
    begin
      int k = 0;
      for (int r = 0; r <= 255; r += 51)
        for (int g = 0; g <= 255; g += 51)
          for (int b = 0; b <= 255; b += 51) begin
            if (k % 2 == 1) push(255 - r, b, g, 0);
            push(r, g, b, 1);
            k++;
          end
    end

    // random stream with random bubbles
    for (int i = 0; i < 2000; i++)
      push($urandom % 256, $urandom % 256, $urandom % 256, ($urandom % 4) != 0);

    for (int i = 0; i < 4; i++) push($urandom % 256, 0, 0, 0);
    @(negedge clk);
    chk(rd_ptr == wr_ptr, "R8 all results delivered", rd_ptr, wr_ptr);
    chk(rd_ptr == wr_ptr, "R9 no extra results", rd_ptr, wr_ptr);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule